// File: doc/BRIEF.md
# Serial-Loaded Bank Control Registers

This block sits on a CPU write path and holds four small bank-select registers that software loads one bit at a time. Each qualifying write (strobe high, address bit 15 set) shifts data bit 0 into an accumulator, least significant bit first. On the fifth such write the 5-bit result is committed to one register. Address bits [14:13] of that fifth write pick the register.

A write with data bit 7 set is a reset command. It drops any partial load. It also forces the two program-mode bits of the control register to ones and changes nothing else. The block's outputs drive address-translation logic elsewhere: a 5-bit control word, two 5-bit character-bank numbers and a 4-bit program-bank number.

Top module: `serial_bank_regs`

## Requirements
- R1: After reset, ctrl_o is 5'h0C and chr0_o, chr1_o and prg_o are zero.
- R2: Five qualifying writes with data bit 7 clear commit a value. Bit i of that value is data bit 0 of write i, with write 0 first, and it appears on the chosen output in the cycle after the fifth write's clock edge.
- R3: Address bits [14:13] of the fifth write alone select the destination: 0 is ctrl_o, 1 is chr0_o, 2 is chr1_o, 3 is prg_o. The addresses of writes 1 to 4 have no effect.
- R4: prg_o takes only bits [3:0] of the committed value, so bit 4 is dropped.
- R5: A qualifying write with data bit 7 set does three things. It ORs 5'h0C into ctrl_o. It leaves chr0_o, chr1_o and prg_o unchanged. It discards the partial load, so the next load starts again at bit 0.
- R6: A write with wr_en_i low, or with addr_i[15] clear, changes no output and does not advance a load in progress.
- R7: During the first four writes of a load, no output changes.
- R8: Data bits [6:1] have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 16 | Write address; bit 15 qualifies the write, bits [14:13] select the register |
| data_i | input | 8 | Write data; bit 0 is the serial bit, bit 7 is the reset command |
| ctrl_o | output | 5 | Control register |
| chr0_o | output | 5 | Character bank 0 register |
| chr1_o | output | 5 | Character bank 1 register |
| prg_o | output | 4 | Program bank register |

## Verification
The bit counter and the accumulator are hidden, so a fault in either shows up only at a commit. A count that is off by one commits after the fourth or sixth write, or commits a value shifted by one position. A counter that survives an abort commits a value rotated by the number of writes that were dropped. A selection fault moves the value to the wrong output. The bench compares all four outputs after every write against a model, so any of these faults appears within five writes of its cause.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned VAL_W  = 5;
  localparam int unsigned PRG_W  = 4;
  localparam int unsigned CNT_W  = $clog2(VAL_W);
  localparam logic [VAL_W-1:0] CTRL_RST   = 5'h0C;
  localparam logic [VAL_W-1:0] CTRL_FORCE = 5'h0C;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHR0 = 2'd1,
    SEL_CHR1 = 2'd2,
    SEL_PRG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/serial_shift_loader.sv
module serial_shift_loader
  import serial_bank_pkg::*;
#(
  parameter int unsigned W  = VAL_W,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         abort_i,
  input  logic         bit_i,
  output logic         commit_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == CW'(W - 1));
  assign commit_o = shift_i & last;

  always_comb begin
    value_o = acc_q;
    for (int i = 0; i < W; i++)
      if (cnt_q == CW'(i)) value_o[i] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (abort_i || commit_o) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      acc_q <= value_o;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_bank_file.sv
module serial_bank_file
  import serial_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [1:0]       sel_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             abort_i,
  output logic [VAL_W-1:0] ctrl_o,
  output logic [VAL_W-1:0] chr_o [2],
  output logic [PRG_W-1:0] prg_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ctrl_o <= CTRL_RST;
    else if (abort_i)                        ctrl_o <= ctrl_o | CTRL_FORCE;
    else if (commit_i && sel == SEL_CTRL)    ctrl_o <= value_i;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chr
    localparam reg_sel_e MY_SEL = (g == 0) ? SEL_CHR0 : SEL_CHR1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          chr_o[g] <= '0;
      else if (commit_i && sel == MY_SEL)   chr_o[g] <= value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            prg_o <= '0;
    else if (commit_i && sel == SEL_PRG)    prg_o <= value_i[PRG_W-1:0];
  end
endmodule

// File: rtl/serial_bank_regs.sv
module serial_bank_regs
  import serial_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [VAL_W-1:0]  ctrl_o,
  output logic [VAL_W-1:0]  chr0_o,
  output logic [VAL_W-1:0]  chr1_o,
  output logic [PRG_W-1:0]  prg_o
);
  logic             hit, abort, shift, commit;
  logic [VAL_W-1:0] value;
  logic [VAL_W-1:0] chr [2];

  assign hit   = wr_en_i & addr_i[ADDR_W-1];
  assign abort = hit & data_i[DATA_W-1];
  assign shift = hit & ~data_i[DATA_W-1];

  serial_shift_loader #(.W(VAL_W)) u_loader (
    .clk_i, .rst_ni,
    .shift_i (shift),
    .abort_i (abort),
    .bit_i   (data_i[0]),
    .commit_o(commit),
    .value_o (value)
  );

  serial_bank_file u_file (
    .clk_i, .rst_ni,
    .commit_i(commit),
    .sel_i   (addr_i[ADDR_W-2:ADDR_W-3]),
    .value_i (value),
    .abort_i (abort),
    .ctrl_o  (ctrl_o),
    .chr_o   (chr),
    .prg_o   (prg_o)
  );

  assign chr0_o = chr[0];
  assign chr1_o = chr[1];
endmodule

// File: rtl/serial_bank_regs_chk.sv
module serial_bank_regs_chk
  import serial_bank_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [VAL_W-1:0]  ctrl_o,
  input logic [VAL_W-1:0]  chr0_o,
  input logic [VAL_W-1:0]  chr1_o,
  input logic [PRG_W-1:0]  prg_o
);
  logic       armed;
  logic [2:0] seen;
  logic       hit, plain, brk;
  logic [1:0] sel;

  assign hit   = wr_en_i & addr_i[ADDR_W-1];
  assign plain = hit & ~data_i[DATA_W-1];
  assign brk   = hit & data_i[DATA_W-1];
  assign sel   = addr_i[ADDR_W-2:ADDR_W-3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      seen  <= '0;
    end else begin
      armed <= 1'b1;
      if (brk) seen <= '0;
      else if (plain) seen <= (seen == 3'(VAL_W - 1)) ? '0 : seen + 1'b1;
    end
  end

  AST_ABORT_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(brk) |-> ctrl_o[3:2] == 2'b11 && $stable(chr0_o) && $stable(chr1_o) && $stable(prg_o)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(hit) |-> $stable(ctrl_o) && $stable(chr0_o) && $stable(chr1_o) && $stable(prg_o)); // R6
  AST_PARTIAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(plain) && $past(seen) != 3'(VAL_W - 1) |->
      $stable(ctrl_o) && $stable(chr0_o) && $stable(chr1_o) && $stable(prg_o)); // R7
  AST_CHR0_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$stable(chr0_o) |-> $past(plain) && $past(sel) == 2'd1); // R3
  AST_PRG_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$stable(prg_o) |-> $past(plain) && $past(sel) == 2'd3); // R3
  AST_CTRL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$stable(ctrl_o) |-> $past(brk) || ($past(plain) && $past(sel) == 2'd0)); // R3
endmodule

bind serial_bank_regs serial_bank_regs_chk u_chk (.*);

// File: tb/serial_bank_regs_tb.sv
module serial_bank_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [4:0]  ctrl_o, chr0_o, chr1_o;
  logic [3:0]  prg_o;

  int errors = 0, checks = 0;
  logic [4:0] m_ctrl, m_chr0, m_chr1, m_acc;
  logic [3:0] m_prg;
  int         m_cnt;

  serial_bank_regs u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string tag, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] pack(logic [4:0] c, logic [4:0] a, logic [4:0] b, logic [3:0] p);
    return {c, a, b, p};
  endfunction

  task automatic model_reset();
    m_ctrl = 5'h0C; m_chr0 = 0; m_chr1 = 0; m_prg = 0; m_acc = 0; m_cnt = 0;
  endtask

  task automatic model_write(logic en, logic [15:0] a, logic [7:0] d);
    if (!(en && a[15])) return;
    if (d[7]) begin
      m_acc = 0; m_cnt = 0; m_ctrl = m_ctrl | 5'h0C;
      return;
    end
    m_acc[m_cnt] = d[0];
    m_cnt++;
    if (m_cnt == 5) begin
      case (a[14:13])
        2'd0: m_ctrl = m_acc;
        2'd1: m_chr0 = m_acc;
        2'd2: m_chr1 = m_acc;
        default: m_prg = m_acc[3:0];
      endcase
      m_acc = 0; m_cnt = 0;
    end
  endtask

  task automatic wr(logic en, logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = en; addr_i = a; data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_write(en, a, d);
  endtask

  // five writes, junk in bits 6:1
  task automatic load(logic [15:0] a, logic [4:0] v);
    for (int i = 0; i < 5; i++)
      wr(1'b1, a, {1'b0, 6'($urandom), v[i]});
  endtask

  task automatic check_model(string tag);
    check(tag, pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(m_ctrl, m_chr0, m_chr1, m_prg));
  endtask

  initial begin
    #(64'd200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset", pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(5'h0C, 0, 0, 0));

    load(16'h8000, 5'h13);
    check("R2 ctrl load", {14'd0, ctrl_o}, {14'd0, 5'h13});
    load(16'hA000, 5'h15);
    check("R2 chr0 load", {14'd0, chr0_o}, {14'd0, 5'h15});
    load(16'hDFFF, 5'h0A);
    check("R3 chr1 load", {14'd0, chr1_o}, {14'd0, 5'h0A});
    load(16'hE000, 5'h1F);
    check("R4 prg drops bit4", {15'd0, prg_o}, {15'd0, 4'hF});

    // R7 partial load holds outputs
    for (int i = 0; i < 4; i++) wr(1'b1, 16'hA000, 8'h01);
    check("R7 partial", pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(5'h13, 5'h15, 5'h0A, 4'hF));
    // R5 abort mid-load
    wr(1'b1, 16'h8000, 8'h80);
    check("R5 abort force", pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(5'h1F, 5'h15, 5'h0A, 4'hF));
    load(16'hA000, 5'h01);
    check("R5 restart bit0", {14'd0, chr0_o}, {14'd0, 5'h01});

    // R3 address of fifth write only
    for (int i = 0; i < 4; i++) wr(1'b1, 16'hA000, 8'h00);
    wr(1'b1, 16'hE000, 8'h01);
    check("R3 fifth addr", pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(5'h1F, 5'h01, 5'h0A, 4'h0));

    // R6 ignored writes interleaved
    wr(1'b1, 16'hC000, 8'h01);
    wr(1'b1, 16'hC000, 8'h00);
    wr(1'b0, 16'hC000, 8'h81);
    wr(1'b1, 16'h4000, 8'h81);
    wr(1'b1, 16'h7FFF, 8'h01);
    check("R6 ignored", pack(ctrl_o, chr0_o, chr1_o, prg_o), pack(5'h1F, 5'h01, 5'h0A, 4'h0));
    wr(1'b1, 16'hC000, 8'h01);
    wr(1'b1, 16'hC000, 8'h00);
    wr(1'b1, 16'hC000, 8'h01);
    check("R6 resumed load", {14'd0, chr1_o}, {14'd0, 5'h15});

    // R8 junk bits
    for (int i = 0; i < 5; i++) wr(1'b1, 16'hA000, 8'h7E);
    check("R8 junk bits", {14'd0, chr0_o}, {14'd0, 5'h00});
    load(16'h8000, 5'h00);
    wr(1'b1, 16'h9000, 8'hFF);
    check("R5 force from zero", {14'd0, ctrl_o}, {14'd0, 5'h0C});

    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom_range(15) != 0) d[7] = 1'b0;
      wr(($urandom_range(7) != 0), {($urandom_range(5) != 0), 15'($urandom)}, d);
      check_model("R2 R3 R5 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule